// File: doc/BRIEF.md
# Sample-indexed twiddle aspect generator

This block produces the complex rotation factor needed by a DFT engine that folds each incoming sample straight into all N bin accumulators instead of buffering a whole frame. It keeps two counters: a sample counter n that steps once per arriving sample, and a bin counter k that steps once per accumulator update. It also keeps a running phase equal to n·k modulo N. That phase is split into a quadrant and an in-quadrant offset. A quarter-wave magnitude table then supplies signed cosine and sine values at a fixed one-cycle latency.

The table stores only the N/4−1 magnitudes that are not 0 or full scale. Phases on the axes produce exact 0 and ±full-scale values directly. A direction select picks the forward kernel e^(−jθ) or the inverse kernel e^(+jθ) by flipping the sign of the sine output. A one-cycle flag marks the cycle in which the sample counter wraps, which is the frame boundary. The multiply-accumulate datapath sits outside this block.

Top module: `twiddle_aspect_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, n_o=0, k_o=0, cos_o=FS, sin_o=0 and frame_wrap_o=0. FS is 2^(W-1)-1.
- R2: A bin_adv_i pulse increments k_o modulo N, so N-1 is followed by 0. A sample_adv_i pulse returns k_o to 0. When both strobes are high in the same cycle, sample_adv_i wins.
- R3: A sample_adv_i pulse increments n_o modulo N. frame_wrap_o is high for exactly the one cycle in which n_o has just gone from N-1 to 0, and low at all other times.
- R4: In a cycle with neither strobe high, n_o and k_o keep their values.
- R5: cos_o equals sgn(c)·floor(FS·|c|+0.5), where c=cos(2π·m/N) and m=(n·k) mod N. Here n and k are the counter values one cycle earlier.
- R6: Let s be sgn·floor(FS·|sin(2π·m/N)|+0.5), with m and the one-cycle delay as in R5. When fwd_i=1 (forward), sin_o=-s. When fwd_i=0 (inverse), sin_o=+s.
- R7: When m is 0, N/4, N/2 or 3N/4, the outputs are exactly 0 or ±FS. For example, m=0 gives cos_o=FS and sin_o=0, and m=N/4 gives cos_o=0 and sin_o=∓FS for forward/inverse.
- R8: A change of fwd_i alone changes sin_o one cycle later and leaves n_o, k_o and cos_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_adv_i | input | 1 | Step sample counter, restart bin sequence |
| bin_adv_i | input | 1 | Step bin counter |
| fwd_i | input | 1 | 1 = forward kernel, 0 = inverse kernel |
| cos_o | output | W | Signed cosine, registered |
| sin_o | output | W | Signed sine with direction sign applied, registered |
| n_o | output | N_LOG2 | Current sample number |
| k_o | output | N_LOG2 | Current bin number |
| frame_wrap_o | output | 1 | One-cycle pulse when sample number wraps to 0 |

## Verification
The assertions assume that both strobes and fwd_i are synchronous to clk_i and are never unknown once reset is released. They also assume that the datapath reading cos_o and sin_o accounts for the one-cycle delay from the counters. The stimulus changes every input on the falling clock edge and uses single-cycle strobe pulses. It raises both strobes together only in a dedicated priority case. The sweep visits every (n, k) pair of a 16-point configuration in both directions, so every quadrant, every axis point and every mirrored table address is exercised.

// File: rtl/twid_pkg.sv
package twid_pkg;
  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;
endpackage

// File: rtl/twid_seq_counters.sv
module twid_seq_counters #(
  parameter int N_LOG2 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_adv_i,
  input  logic              bin_adv_i,
  output logic [N_LOG2-1:0] n_o,
  output logic [N_LOG2-1:0] k_o,
  output logic [N_LOG2-1:0] phase_o,
  output logic              wrap_o
);
  localparam logic [N_LOG2-1:0] IDX_MAX = {N_LOG2{1'b1}};

  logic [N_LOG2-1:0] n_q, k_q, ph_q;
  logic              wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      k_q    <= '0;
      ph_q   <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= sample_adv_i && (n_q == IDX_MAX);
      if (sample_adv_i) begin
        n_q  <= n_q + 1'b1;
        k_q  <= '0;
        ph_q <= '0;
      end else if (bin_adv_i) begin
        k_q  <= k_q + 1'b1;
        // n*(k+1) = n*k + n; natural width wrap gives mod N
        ph_q <= ph_q + n_q;
      end
    end
  end

  assign n_o     = n_q;
  assign k_o     = k_q;
  assign phase_o = ph_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/twid_quarter_rom.sv
module twid_quarter_rom #(
  parameter int N_LOG2 = 6,
  parameter int W      = 12
) (
  input  logic [N_LOG2-3:0] idx_i,
  output logic [W-2:0]      mag_o
);
  localparam int N  = 1 << N_LOG2;
  localparam int Q  = N / 4;
  localparam int FS = (1 << (W - 1)) - 1;

  logic [W-2:0] tbl [Q];

  for (genvar j = 0; j < Q; j++) begin : g_ent
    if (j == 0) begin : g_zero
      assign tbl[j] = '0;
    end else begin : g_val
      localparam real ANG = 6.283185307179586 * real'(j) / real'(N);
      localparam int  VAL = $rtoi(real'(FS) * $sin(ANG) + 0.5);
      assign tbl[j] = (W-1)'(VAL);
    end
  end

  assign mag_o = tbl[idx_i];
endmodule

// File: rtl/twid_fold.sv
module twid_fold
  import twid_pkg::*;
#(
  parameter int N_LOG2 = 6,
  parameter int W      = 12
) (
  input  logic [N_LOG2-1:0]    phase_i,
  input  logic                 fwd_i,
  input  logic [W-2:0]         mag_dir_i,
  input  logic [W-2:0]         mag_mir_i,
  output logic [N_LOG2-3:0]    idx_dir_o,
  output logic [N_LOG2-3:0]    idx_mir_o,
  output logic signed [W-1:0]  cos_o,
  output logic signed [W-1:0]  sin_o
);
  localparam logic signed [W-1:0] FS = W'((1 << (W - 1)) - 1);

  quad_e                quad;
  logic [N_LOG2-3:0]    off;
  logic                 on_axis;
  logic signed [W-1:0]  sd, sm, c, s;

  assign quad      = quad_e'(phase_i[N_LOG2-1 -: 2]);
  assign off       = phase_i[N_LOG2-3:0];
  assign on_axis   = (off == '0);
  assign idx_dir_o = off;
  assign idx_mir_o = -off;  // Q - off, modulo Q
  assign sd        = signed'({1'b0, mag_dir_i});
  assign sm        = signed'({1'b0, mag_mir_i});

  always_comb begin
    unique case (quad)
      QUAD_0: begin
        c = on_axis ? FS : sm;
        s = on_axis ? '0 : sd;
      end
      QUAD_1: begin
        c = on_axis ? '0 : -sd;
        s = on_axis ? FS : sm;
      end
      QUAD_2: begin
        c = on_axis ? -FS : -sm;
        s = on_axis ? '0  : -sd;
      end
      default: begin
        c = on_axis ? '0  : sd;
        s = on_axis ? -FS : -sm;
      end
    endcase
  end

  assign cos_o = c;
  assign sin_o = fwd_i ? -s : s;
endmodule

// File: rtl/twiddle_aspect_gen.sv
module twiddle_aspect_gen #(
  parameter int N_LOG2 = 6,
  parameter int W      = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_adv_i,
  input  logic                bin_adv_i,
  input  logic                fwd_i,
  output logic signed [W-1:0] cos_o,
  output logic signed [W-1:0] sin_o,
  output logic [N_LOG2-1:0]   n_o,
  output logic [N_LOG2-1:0]   k_o,
  output logic                frame_wrap_o
);
  localparam int                  R_W = N_LOG2 - 2;
  localparam logic signed [W-1:0] FS  = W'((1 << (W - 1)) - 1);

  logic [N_LOG2-1:0]   phase;
  logic [R_W-1:0]      idx [2];
  logic [W-2:0]        mag [2];
  logic signed [W-1:0] cos_d, sin_d;
  logic signed [W-1:0] cos_q, sin_q;

  twid_seq_counters #(.N_LOG2(N_LOG2)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_adv_i (sample_adv_i),
    .bin_adv_i    (bin_adv_i),
    .n_o          (n_o),
    .k_o          (k_o),
    .phase_o      (phase),
    .wrap_o       (frame_wrap_o)
  );

  // two read ports: direct offset and mirrored offset
  for (genvar p = 0; p < 2; p++) begin : g_port
    twid_quarter_rom #(.N_LOG2(N_LOG2), .W(W)) u_rom (
      .idx_i (idx[p]),
      .mag_o (mag[p])
    );
  end

  twid_fold #(.N_LOG2(N_LOG2), .W(W)) u_fold (
    .phase_i   (phase),
    .fwd_i     (fwd_i),
    .mag_dir_i (mag[0]),
    .mag_mir_i (mag[1]),
    .idx_dir_o (idx[0]),
    .idx_mir_o (idx[1]),
    .cos_o     (cos_d),
    .sin_o     (sin_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_q <= FS;
      sin_q <= '0;
    end else begin
      cos_q <= cos_d;
      sin_q <= sin_d;
    end
  end

  assign cos_o = cos_q;
  assign sin_o = sin_q;
endmodule

// File: rtl/twid_gen_chk.sv
module twid_gen_chk #(
  parameter int N_LOG2 = 6,
  parameter int W      = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_adv_i,
  input logic                bin_adv_i,
  input logic                fwd_i,
  input logic signed [W-1:0] cos_o,
  input logic signed [W-1:0] sin_o,
  input logic [N_LOG2-1:0]   n_o,
  input logic [N_LOG2-1:0]   k_o,
  input logic                frame_wrap_o
);
  localparam int                  IDX_W = N_LOG2;
  localparam int                  N     = 1 << N_LOG2;
  localparam logic signed [W-1:0] FS    = W'((1 << (W - 1)) - 1);

  logic [2*N_LOG2-1:0] prod;
  logic [N_LOG2-1:0]   m_now;
  assign prod  = n_o * k_o;
  assign m_now = prod[N_LOG2-1:0];

  p_wrap_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap_o |-> (n_o == '0) && (k_o == '0));

  p_k_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_adv_i |=> (k_o == '0));

  p_k_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_adv_i && !sample_adv_i) |=> (k_o == IDX_W'($past(k_o) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bin_adv_i && !sample_adv_i) |=> ($stable(n_o) && $stable(k_o)));

  p_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_now == '0) |=> (cos_o == FS) && (sin_o == '0));

  p_quarter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_now == IDX_W'(N / 4)) |=> (cos_o == '0) && (sin_o == ($past(fwd_i) ? -FS : FS)));
endmodule

bind twiddle_aspect_gen twid_gen_chk #(.N_LOG2(N_LOG2), .W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_adv_i (sample_adv_i),
  .bin_adv_i    (bin_adv_i),
  .fwd_i        (fwd_i),
  .cos_o        (cos_o),
  .sin_o        (sin_o),
  .n_o          (n_o),
  .k_o          (k_o),
  .frame_wrap_o (frame_wrap_o)
);

// File: tb/twiddle_aspect_gen_bench.sv
module twiddle_aspect_gen_bench;
  localparam int N_LOG2 = 4;
  localparam int W      = 10;
  localparam int N      = 1 << N_LOG2;
  localparam int FS     = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_adv = 1'b0, bin_adv = 1'b0, fwd = 1'b1;
  logic signed [W-1:0] cos_w, sin_w;
  logic [N_LOG2-1:0]   n_w, k_w;
  logic                wrap_w;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  twiddle_aspect_gen #(.N_LOG2(N_LOG2), .W(W)) u_twiddle_aspect_gen (
    .clk_i(clk), .rst_ni(rst_ni), .sample_adv_i(sample_adv), .bin_adv_i(bin_adv),
    .fwd_i(fwd), .cos_o(cos_w), .sin_o(sin_w), .n_o(n_w), .k_o(k_w),
    .frame_wrap_o(wrap_w)
  );

  function automatic int rnd(real x);
    real a = (x < 0.0) ? -x : x;
    int  v = $rtoi(a * real'(FS) + 0.5);
    return (x < 0.0) ? -v : v;
  endfunction

  function automatic int exp_cos(int m);
    return rnd($cos(6.283185307179586 * real'(m) / real'(N)));
  endfunction

  function automatic int exp_sin(int m, bit f);
    int s = rnd($sin(6.283185307179586 * real'(m) / real'(N)));
    return f ? -s : s;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse(bit s, bit b);
    sample_adv = s; bin_adv = b;
    @(negedge clk);
    sample_adv = 1'b0; bin_adv = 1'b0;
  endtask

  task automatic check_tw(int n, int k, bit f);
    int m = (n * k) % N;
    chk(int'(cos_w) == exp_cos(m), "R5 cos", int'(cos_w), exp_cos(m));
    chk(int'(sin_w) == exp_sin(m, f), "R6 sin", int'(sin_w), exp_sin(m, f));
    if (m % (N / 4) == 0)
      chk((cos_w == 0 || cos_w == FS || cos_w == -FS), "R7 axis", int'(cos_w), exp_cos(m));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(n_w == 0 && k_w == 0, "R1 counters", int'(n_w) + int'(k_w), 0);
    chk(int'(cos_w) == FS && sin_w == 0, "R1 cos", int'(cos_w), FS);
    chk(wrap_w == 1'b0, "R1 wrap", int'(wrap_w), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(int'(cos_w) == FS && sin_w == 0 && n_w == 0, "R1 after release", int'(cos_w), FS);

    for (int n = 0; n < N; n++) begin
      for (int k = 0; k < N; k++) begin
        @(negedge clk);  // let output register follow counters
        chk(int'(n_w) == n, "R3 n", int'(n_w), n);
        chk(int'(k_w) == k, "R2 k", int'(k_w), k);
        chk(wrap_w == 1'b0, "R3 wrap low", int'(wrap_w), 0);
        check_tw(n, k, 1'b1);
        fwd = 1'b0;
        @(negedge clk);
        check_tw(n, k, 1'b0);
        chk(int'(k_w) == k && int'(n_w) == n, "R8 counters kept", int'(k_w), k);
        fwd = 1'b1;
        @(negedge clk);
        chk(int'(k_w) == k && int'(n_w) == n, "R4 hold", int'(k_w), k);
        if (k < N - 1) pulse(1'b0, 1'b1);
      end
      pulse(1'b0, 1'b1);
      chk(k_w == 0, "R2 k wrap", int'(k_w), 0);
      pulse(1'b1, 1'b0);
      chk(wrap_w == (n == N - 1), "R3 wrap pulse", int'(wrap_w), int'(n == N - 1));
      chk(int'(n_w) == (n + 1) % N, "R3 n step", int'(n_w), (n + 1) % N);
    end

    @(negedge clk);
    chk(wrap_w == 1'b0, "R3 wrap one cycle", int'(wrap_w), 0);

    repeat (3) pulse(1'b0, 1'b1);
    chk(k_w == 3, "R2 pre-priority", int'(k_w), 3);
    pulse(1'b1, 1'b1);
    chk(k_w == 0, "R2 priority k", int'(k_w), 0);
    chk(n_w == 1, "R2 priority n", int'(n_w), 1);
    @(negedge clk);
    check_tw(1, 0, 1'b1);

    repeat (5) pulse(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(k_w == 5 && n_w == 1, "R4 idle hold", int'(k_w), 5);
    check_tw(1, 5, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule